// File: doc/BRIEF.md
# NAND Command Cycle Sequencer

This block runs one raw NAND flash operation on the flash pins. Software loads opcodes, a column address, a row address, a byte count, strobe timing and a 15-bit code word. Each code bit enables one kind of bus cycle. Writing the start bit makes the engine step through the enabled cycles from the highest code bit to the lowest, skipping every cleared bit. While it steps, the engine drives CLE, ALE, the write and read strobes, the chip enables and the 8-bit I/O bus.

Data for a program cycle comes from an internal byte buffer, starting at address 0. Bytes read in a read-data cycle go to the same buffer, also from address 0. A read-status cycle stores its byte in a status register, and a read-ID cycle stores its bytes in an ID register. A ready/busy wait cycle first lets a fixed delay pass. It then stalls until the selected ready lines are high, and it gives up after a bounded number of clocks. When the engine goes back to idle it sets flags that software can clear, and the idle flag can raise an interrupt.

Top module: `nand_seq`

## Requirements
- R1: After reset the engine is idle, every chip enable is high, both strobes are high, CLE, ALE and irq are low, and the control register reads 0.
- R2: Enabled cycles run in descending code-bit order, and cleared bits produce no cycle. Command cycles are at bit 14 (opcode CTRL[31:24]), bit 7 (opcode CMD[31:24]) and bit 4 (opcode CMD[23:16]). Each command cycle drives CLE high with its opcode on I/O. The code word is CTRL[22:8], and CTRL[0] is start.
- R3: Code bit b in 13..9 sends address byte index 13-b with ALE high. Indexes 0 and 1 are COL[7:0] and COL[15:8]. Indexes 2, 3 and 4 are ROW[7:0], ROW[15:8] and ROW[23:16].
- R4: Bit 8 sends SIZE bytes from buffer addresses 0 upward on write strobes, with I/O driven. Bit 5 makes SIZE read strobes and stores the bytes at buffer addresses 0 upward. A SIZE of 0 skips either data phase. I/O is never driven while the read strobe is low.
- R5: Bit 3 makes one read strobe and stores the byte in STAT[7:0]. Bit 2 makes four read strobes and stores the bytes in ID, first byte in ID[7:0].
- R6: Each strobe stays low for TIM[3:0]+1 clocks and then high for at least TIM[7:4]+1 clocks. The two strobes are never low together, CLE and ALE are never high together, and I/O is stable while the write strobe is low.
- R7: During an operation the chip enables equal the inverse of ROW[27:24]. When idle they are all high.
- R8: Bit 6 waits TWB clocks and then stalls until every ready line selected by ROW[31:28] is high. If no line is selected, the wait ends at once. No later cycle starts before the wait ends.
- R9: If a selected ready line stays low for RB_TIMEOUT clocks, the engine drops the remaining cycles, sets the error flag IRQ[28] and leaves the done flag clear.
- R10: A normal finish sets the done flag IRQ[30]. Every finish sets the idle flag IRQ[29]. irq is the idle flag AND the enable IRQ[20]. Writing 1 to IRQ[18], IRQ[17] or IRQ[16] clears the done, idle or error flag.
- R11: While the engine is busy, writes to CTRL, CMD, COL, ROW, SIZE and TIM are ignored, host buffer writes are ignored, and CTRL[0] reads 1.
- R12: A SIZE write larger than BUF_DEPTH stores BUF_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address (0 CTRL, 1 CMD, 2 COL, 3 ROW, 4 SIZE, 5 TIM, 6 IRQ, 7 STAT, 8 ID) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| buf_we | input | 1 | Host buffer write |
| buf_addr | input | AW | Host buffer address |
| buf_wdata | input | 8 | Host buffer write byte |
| buf_rdata | output | 8 | Host buffer read byte, one clock after the address |
| irq | output | 1 | Idle interrupt |
| nand_ce_n | output | NUM_CE | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | I/O bus output byte |
| nand_io_oe | output | 1 | I/O bus output enable |
| nand_io_in | input | 8 | I/O bus input byte |
| nand_rb | input | NUM_CE | Ready/busy lines, high = ready |

## Verification
The bench uses random code words, including sparse, dense and zero-size data phases, to test the ordering rule. An engine that scanned the bits in the wrong direction, or that mapped an address bit to the wrong byte index, would produce a strobe log that differs from the bench's own walk of the code word.

Directed cases cover the following:
- A wait with the ready line held low. A design that did not stall would emit the trailing command early.
- A wait that times out. A design without the abort would hang, or would leave the done flag set.
- A wait with an empty ready-line selection. A design that waited anyway would hit the timeout.
- Register writes made during busy. A design that accepted them would change the column readback.
- A saturating SIZE write.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_NEXT, ST_SETUP, ST_LOW, ST_HIGH, ST_TWB, ST_RB, ST_END
  } seq_st_e;

  localparam logic [3:0] B_CMD1 = 4'd14;
  localparam logic [3:0] B_WR   = 4'd8;
  localparam logic [3:0] B_CMD2 = 4'd7;
  localparam logic [3:0] B_RB   = 4'd6;
  localparam logic [3:0] B_RD   = 4'd5;
  localparam logic [3:0] B_CMD3 = 4'd4;
  localparam logic [3:0] B_STAT = 4'd3;
  localparam logic [3:0] B_ID   = 4'd2;

  // highest enabled code bit strictly below 'from'; 0 when none remains
  function automatic logic [3:0] next_step(input logic [14:0] code, input logic [3:0] from);
    logic [3:0] f;
    f = 4'd0;
    for (int b = 2; b <= 14; b++)
      if (code[b] && (b < int'(from))) f = 4'(b);
    return f;
  endfunction

  function automatic logic is_cmd(input logic [3:0] b);
    return (b == B_CMD1) || (b == B_CMD2) || (b == B_CMD3);
  endfunction

  function automatic logic is_addr(input logic [3:0] b);
    return (b >= 4'd9) && (b <= 4'd13);
  endfunction

  function automatic logic is_rd(input logic [3:0] b);
    return (b == B_RD) || (b == B_STAT) || (b == B_ID);
  endfunction

  function automatic logic is_wr(input logic [3:0] b);
    return is_cmd(b) || is_addr(b) || (b == B_WR);
  endfunction

  function automatic logic is_data(input logic [3:0] b);
    return (b == B_WR) || (b == B_RD);
  endfunction

  // address byte for code bit b: index 13-b, column bytes first then row bytes
  function automatic logic [7:0] addr_byte(input logic [3:0] b, input logic [15:0] col,
                                           input logic [23:0] row);
    logic [3:0] k;
    k = 4'd13 - b;
    case (k)
      4'd0:    return col[7:0];
      4'd1:    return col[15:8];
      4'd2:    return row[7:0];
      4'd3:    return row[15:8];
      default: return row[23:16];
    endcase
  endfunction

  function automatic logic [31:0] sat_size(input logic [31:0] req, input int unsigned depth);
    return (req > depth) ? depth : req;
  endfunction

endpackage

// File: rtl/nand_seq_buf.sv
module nand_seq_buf #(
  parameter int DEPTH = 2304,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] eng_addr,
  input  logic          eng_we,
  input  logic [7:0]    eng_wdata,
  output logic [7:0]    eng_rdata,
  input  logic [AW-1:0] host_addr,
  input  logic          host_we,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (eng_we) mem[eng_addr] <= eng_wdata;
    else if (host_we) mem[host_addr] <= host_wdata;
    host_rdata <= mem[host_addr];
  end

  assign eng_rdata = mem[eng_addr];
endmodule

// File: rtl/nand_seq_regs.sv
module nand_seq_regs import nand_seq_pkg::*; #(
  parameter int BUF_DEPTH = 2304,
  parameter int ID_BYTES  = 4,
  localparam int SZW  = $clog2(BUF_DEPTH + 1),
  localparam int IDIW = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [3:0]            reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic                  busy,
  input  logic                  ev_end,
  input  logic                  ev_abort,
  input  logic                  stat_we,
  input  logic                  id_we,
  input  logic [IDIW-1:0]       id_idx,
  input  logic [7:0]            cap_byte,
  output logic                  start,
  output logic [14:0]           code,
  output logic [7:0]            cmd1,
  output logic [7:0]            cmd2,
  output logic [7:0]            cmd3,
  output logic [15:0]           col,
  output logic [23:0]           row,
  output logic [3:0]            cs,
  output logic [3:0]            rbsel,
  output logic [SZW-1:0]        size,
  output logic [3:0]            pw_m1,
  output logic [3:0]            hold_m1,
  output logic                  idle_flag,
  output logic                  done_flag,
  output logic                  err_flag,
  output logic                  irq
);
  localparam int IDW = 8 * ID_BYTES;

  logic            irq_en;
  logic [7:0]      stat_q;
  logic [IDW-1:0]  id_q;
  logic            cfg_wr;

  assign cfg_wr = reg_wr && !busy;
  assign start  = cfg_wr && (reg_addr == 4'd0) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0; cmd1 <= '0; cmd2 <= '0; cmd3 <= '0;
      col <= '0; row <= '0; cs <= '0; rbsel <= '0;
      size <= '0; pw_m1 <= '0; hold_m1 <= '0;
    end else if (cfg_wr) begin
      case (reg_addr)
        4'd0: begin cmd1 <= reg_wdata[31:24]; code <= reg_wdata[22:8]; end
        4'd1: begin cmd2 <= reg_wdata[31:24]; cmd3 <= reg_wdata[23:16]; end
        4'd2: col <= reg_wdata[15:0];
        4'd3: begin row <= reg_wdata[23:0]; cs <= reg_wdata[27:24]; rbsel <= reg_wdata[31:28]; end
        4'd4: size <= SZW'(sat_size(reg_wdata, BUF_DEPTH));
        4'd5: begin pw_m1 <= reg_wdata[3:0]; hold_m1 <= reg_wdata[7:4]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en <= 1'b0; idle_flag <= 1'b0; done_flag <= 1'b0; err_flag <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == 4'd6) begin
        irq_en <= reg_wdata[20];
        if (reg_wdata[18]) done_flag <= 1'b0;
        if (reg_wdata[17]) idle_flag <= 1'b0;
        if (reg_wdata[16]) err_flag  <= 1'b0;
      end
      if (ev_end) idle_flag <= 1'b1;
      if (ev_end && !ev_abort) done_flag <= 1'b1;
      if (ev_abort) err_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0; id_q <= '0;
    end else begin
      if (stat_we) stat_q <= cap_byte;
      if (id_we) id_q[8*id_idx +: 8] <= cap_byte;
    end
  end

  assign irq = idle_flag && irq_en;

  always_comb begin
    case (reg_addr)
      4'd0: reg_rdata = {cmd1, 1'b0, code, 7'b0, busy};
      4'd1: reg_rdata = {cmd2, cmd3, 16'b0};
      4'd2: reg_rdata = {16'b0, col};
      4'd3: reg_rdata = {rbsel, cs, row};
      4'd4: reg_rdata = 32'(size);
      4'd5: reg_rdata = {24'b0, hold_m1, pw_m1};
      4'd6: reg_rdata = {1'b0, done_flag, idle_flag, err_flag, 7'b0, irq_en, 20'b0};
      4'd7: reg_rdata = {24'b0, stat_q};
      4'd8: reg_rdata = 32'(id_q);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/nand_seq_eng.sv
module nand_seq_eng import nand_seq_pkg::*; #(
  parameter int BUF_DEPTH  = 2304,
  parameter int NUM_CE     = 4,
  parameter int TWB        = 4,
  parameter int RB_TIMEOUT = 4096,
  parameter int ID_BYTES   = 4,
  localparam int SZW  = $clog2(BUF_DEPTH + 1),
  localparam int AW   = $clog2(BUF_DEPTH),
  localparam int IDIW = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [14:0]       code,
  input  logic [7:0]        cmd1,
  input  logic [7:0]        cmd2,
  input  logic [7:0]        cmd3,
  input  logic [15:0]       col,
  input  logic [23:0]       row,
  input  logic [NUM_CE-1:0] cs,
  input  logic [NUM_CE-1:0] rbsel,
  input  logic [SZW-1:0]    size,
  input  logic [3:0]        pw_m1,
  input  logic [3:0]        hold_m1,
  input  logic [NUM_CE-1:0] rb_in,
  input  logic [7:0]        io_in,
  output logic [NUM_CE-1:0] ce_n,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic [7:0]        io_out,
  output logic              io_oe,
  output logic [AW-1:0]     buf_addr,
  output logic              buf_we,
  input  logic [7:0]        buf_rdata,
  output logic              stat_we,
  output logic              id_we,
  output logic [IDIW-1:0]   id_idx,
  output logic              busy,
  output logic              ev_end,
  output logic              ev_abort
);
  localparam int TW = $clog2(RB_TIMEOUT + TWB + 32);

  seq_st_e      st;
  logic [3:0]   cur;
  logic [SZW-1:0] bcnt;
  logic [TW-1:0]  tcnt;
  logic [7:0]   io_q;
  logic         aborted;

  logic [3:0]   nxt;
  logic [SZW:0] nb;
  logic [7:0]   out_byte;
  logic         in_byte;
  logic         capture;
  logic         rb_ok;
  logic         pw_hit;
  logic         hold_hit;

  assign nxt      = next_step(code, cur);
  assign rb_ok    = &(rb_in | ~rbsel);
  assign pw_hit   = (tcnt == TW'(pw_m1));
  assign hold_hit = (tcnt == TW'(hold_m1));

  always_comb begin
    if (is_data(cur))      nb = {1'b0, size};
    else if (cur == B_ID)  nb = (SZW+1)'(ID_BYTES);
    else                   nb = (SZW+1)'(1);
  end

  always_comb begin
    case (cur)
      B_CMD1:  out_byte = cmd1;
      B_CMD2:  out_byte = cmd2;
      B_CMD3:  out_byte = cmd3;
      B_WR:    out_byte = buf_rdata;
      default: out_byte = addr_byte(cur, col, row);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cur <= '0; bcnt <= '0; tcnt <= '0; io_q <= '0; aborted <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          cur <= 4'd15; aborted <= 1'b0; st <= ST_NEXT;
        end
        ST_NEXT: begin
          bcnt <= '0; tcnt <= '0; cur <= nxt;
          if (nxt == 4'd0)                          st <= ST_END;
          else if (nxt == B_RB)                     st <= ST_TWB;
          else if (is_data(nxt) && size == '0)      st <= ST_NEXT;
          else                                      st <= ST_SETUP;
        end
        ST_SETUP: begin
          io_q <= out_byte; tcnt <= '0; st <= ST_LOW;
        end
        ST_LOW: begin
          if (pw_hit) begin tcnt <= '0; st <= ST_HIGH; end
          else tcnt <= tcnt + 1'b1;
        end
        ST_HIGH: begin
          if (hold_hit) begin
            tcnt <= '0;
            if (({1'b0, bcnt} + 1'b1) >= nb) st <= ST_NEXT;
            else begin bcnt <= bcnt + 1'b1; st <= ST_SETUP; end
          end else tcnt <= tcnt + 1'b1;
        end
        ST_TWB: begin
          if (tcnt == TW'(TWB - 1)) begin tcnt <= '0; st <= ST_RB; end
          else tcnt <= tcnt + 1'b1;
        end
        ST_RB: begin
          if (rb_ok) st <= ST_NEXT;
          else if (tcnt == TW'(RB_TIMEOUT - 1)) begin aborted <= 1'b1; st <= ST_END; end
          else tcnt <= tcnt + 1'b1;
        end
        ST_END:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st != ST_IDLE);
  assign in_byte  = (st == ST_SETUP) || (st == ST_LOW) || (st == ST_HIGH);
  assign capture  = (st == ST_LOW) && pw_hit && is_rd(cur);
  assign cle      = in_byte && is_cmd(cur);
  assign ale      = in_byte && is_addr(cur);
  assign io_oe    = in_byte && is_wr(cur);
  assign we_n     = !((st == ST_LOW) && is_wr(cur));
  assign re_n     = !((st == ST_LOW) && is_rd(cur));
  assign io_out   = io_q;
  assign ce_n     = busy ? ~cs : '1;
  assign buf_addr = AW'(bcnt);
  assign buf_we   = capture && (cur == B_RD);
  assign stat_we  = capture && (cur == B_STAT);
  assign id_we    = capture && (cur == B_ID);
  assign id_idx   = IDIW'(bcnt);
  assign ev_end   = (st == ST_END);
  assign ev_abort = ev_end && aborted;
endmodule

// File: rtl/nand_seq.sv
module nand_seq import nand_seq_pkg::*; #(
  parameter int BUF_DEPTH  = 2304,
  parameter int NUM_CE     = 4,
  parameter int TWB        = 4,
  parameter int RB_TIMEOUT = 4096,
  parameter int ID_BYTES   = 4,
  localparam int AW = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              buf_we,
  input  logic [AW-1:0]     buf_addr,
  input  logic [7:0]        buf_wdata,
  output logic [7:0]        buf_rdata,
  output logic              irq,
  output logic [NUM_CE-1:0] nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_io_out,
  output logic              nand_io_oe,
  input  logic [7:0]        nand_io_in,
  input  logic [NUM_CE-1:0] nand_rb
);
  localparam int SZW  = $clog2(BUF_DEPTH + 1);
  localparam int IDIW = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;

  logic            start, busy, ev_end, ev_abort;
  logic            stat_we, id_we, eng_we;
  logic [IDIW-1:0] id_idx;
  logic [14:0]     code;
  logic [7:0]      cmd1, cmd2, cmd3, eng_rdata;
  logic [15:0]     col;
  logic [23:0]     row;
  logic [3:0]      cs_r, rbsel_r, pw_m1, hold_m1;
  logic [SZW-1:0]  size;
  logic [AW-1:0]   eng_addr;
  logic            idle_flag, done_flag, err_flag;

  nand_seq_regs #(.BUF_DEPTH(BUF_DEPTH), .ID_BYTES(ID_BYTES)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .busy, .ev_end, .ev_abort, .stat_we, .id_we, .id_idx, .cap_byte(nand_io_in),
    .start, .code, .cmd1, .cmd2, .cmd3, .col, .row, .cs(cs_r), .rbsel(rbsel_r),
    .size, .pw_m1, .hold_m1, .idle_flag, .done_flag, .err_flag, .irq
  );

  nand_seq_eng #(.BUF_DEPTH(BUF_DEPTH), .NUM_CE(NUM_CE), .TWB(TWB),
                 .RB_TIMEOUT(RB_TIMEOUT), .ID_BYTES(ID_BYTES)) u_eng (
    .clk, .rst_n, .start, .code, .cmd1, .cmd2, .cmd3, .col, .row,
    .cs(NUM_CE'(cs_r)), .rbsel(NUM_CE'(rbsel_r)), .size, .pw_m1, .hold_m1,
    .rb_in(nand_rb), .io_in(nand_io_in), .ce_n(nand_ce_n), .cle(nand_cle),
    .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n), .io_out(nand_io_out),
    .io_oe(nand_io_oe), .buf_addr(eng_addr), .buf_we(eng_we), .buf_rdata(eng_rdata),
    .stat_we, .id_we, .id_idx, .busy, .ev_end, .ev_abort
  );

  nand_seq_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk, .eng_addr, .eng_we, .eng_wdata(nand_io_in), .eng_rdata,
    .host_addr(buf_addr), .host_we(buf_we && !busy), .host_wdata(buf_wdata),
    .host_rdata(buf_rdata)
  );
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk #(
  parameter int NUM_CE = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we_n,
  input logic              re_n,
  input logic              cle,
  input logic              ale,
  input logic              io_oe,
  input logic [7:0]        io_out,
  input logic [NUM_CE-1:0] ce_n,
  input logic              busy,
  input logic              ev_end,
  input logic              ev_abort,
  input logic              idle_flag,
  input logic              err_flag
);
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n));
  p_cle_ale_r6:    assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
  p_io_hold_r6:    assert property (@(posedge clk) disable iff (!rst_n)
                     (!we_n && $past(!we_n)) |-> $stable(io_out));
  p_no_drive_r4:   assert property (@(posedge clk) disable iff (!rst_n) !re_n |-> !io_oe);
  p_ce_idle_r7:    assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (&ce_n));
  p_idle_flag_r10: assert property (@(posedge clk) disable iff (!rst_n) ev_end |=> idle_flag);
  p_end_idle_r10:  assert property (@(posedge clk) disable iff (!rst_n) ev_end |=> !busy);
  p_abort_err_r9:  assert property (@(posedge clk) disable iff (!rst_n) ev_abort |=> err_flag);
endmodule

bind nand_seq nand_seq_chk #(.NUM_CE(NUM_CE)) u_chk (
  .clk(clk), .rst_n(rst_n), .we_n(nand_we_n), .re_n(nand_re_n), .cle(nand_cle),
  .ale(nand_ale), .io_oe(nand_io_oe), .io_out(nand_io_out), .ce_n(nand_ce_n),
  .busy(busy), .ev_end(ev_end), .ev_abort(ev_abort), .idle_flag(idle_flag),
  .err_flag(err_flag)
);

// File: tb/tb_nand_seq.sv
module tb_nand_seq;
  localparam int DEPTH = 2304;
  localparam int AW    = $clog2(DEPTH);
  localparam int TOUT  = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic buf_we = 1'b0;
  logic [AW-1:0] buf_addr = '0;
  logic [7:0] buf_wdata = '0;
  logic [7:0] buf_rdata;
  logic irq;
  logic [3:0] nand_ce_n;
  logic nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0] nand_io_out;
  logic [7:0] nand_io_in = 8'h00;
  logic [3:0] nand_rb = 4'hF;

  int n_chk = 0, n_fail = 0;
  bit mon_on = 0;
  int we_cnt = 0, re_cnt = 0;
  logic [7:0] log_b [256];
  logic       log_c [256];
  logic       log_a [256];
  logic [3:0] log_ce [256];
  int lowrun = 0, last_we_low = 0, last_re_low = 0;

  logic [7:0] exp_b [256];
  logic       exp_c [256];
  logic       exp_a [256];
  int exp_n;
  logic [7:0] mdl [16];

  always #5 clk = ~clk;

  nand_seq #(.BUF_DEPTH(DEPTH), .RB_TIMEOUT(TOUT)) dut (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .buf_we, .buf_addr, .buf_wdata, .buf_rdata, .irq,
    .nand_ce_n, .nand_cle, .nand_ale, .nand_we_n, .nand_re_n,
    .nand_io_out, .nand_io_oe, .nand_io_in, .nand_rb
  );

  function automatic logic [7:0] sbyte(input int k);
    return 8'((k * 37) + 90);
  endfunction

  // flash model: logs every write strobe, answers read strobes from a stream
  always @(posedge nand_we_n) if (mon_on && we_cnt < 256) begin
    log_b[we_cnt] = nand_io_out; log_c[we_cnt] = nand_cle;
    log_a[we_cnt] = nand_ale;    log_ce[we_cnt] = nand_ce_n;
    we_cnt++;
  end
  always @(negedge nand_re_n) if (mon_on) begin
    nand_io_in = sbyte(re_cnt);
    re_cnt++;
  end
  always @(negedge clk) if (mon_on) begin
    if (!nand_we_n || !nand_re_n) lowrun++;
    else if (lowrun != 0) begin
      if (last_re_low < 0) last_re_low = lowrun; else last_we_low = lowrun;
      lowrun = 0;
    end
  end
  always @(negedge nand_re_n) last_re_low = -1;
  always @(posedge nand_re_n) if (mon_on) last_re_low = -1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wbuf(input int a, input logic [7:0] d);
    @(negedge clk); buf_we = 1'b1; buf_addr = AW'(a); buf_wdata = d;
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic rbuf(input int a, output logic [7:0] d);
    @(negedge clk); buf_addr = AW'(a);
    @(negedge clk); d = buf_rdata;
  endtask

  task automatic wait_irq(output bit got);
    got = 0;
    for (int i = 0; i < 20000 && !got; i++) begin
      @(negedge clk);
      if (irq) got = 1;
    end
  endtask

  task automatic arm();
    wreg(4'd6, 32'h0017_0000);   // enable, clear all flags
    we_cnt = 0; re_cnt = 0; last_we_low = 0; last_re_low = 0; lowrun = 0;
    mon_on = 1;
  endtask

  task automatic go(input logic [7:0] c1, input logic [14:0] code);
    wreg(4'd0, {c1, 1'b0, code, 7'b0, 1'b1});
  endtask

  task automatic build_exp(input logic [14:0] code, input logic [7:0] c1, input logic [7:0] c2,
                           input logic [7:0] c3, input logic [15:0] col, input logic [23:0] row,
                           input int size);
    exp_n = 0;
    for (int b = 14; b >= 2; b--) begin
      if (!code[b]) continue;
      if (b == 14 || b == 7 || b == 4) begin
        exp_b[exp_n] = (b == 14) ? c1 : (b == 7) ? c2 : c3;
        exp_c[exp_n] = 1; exp_a[exp_n] = 0; exp_n++;
      end else if (b >= 9) begin
        logic [39:0] ab;
        ab = {row, col};
        exp_b[exp_n] = ab[8*(13-b) +: 8]; exp_c[exp_n] = 0; exp_a[exp_n] = 1; exp_n++;
      end else if (b == 8) begin
        for (int i = 0; i < size; i++) begin
          exp_b[exp_n] = mdl[i]; exp_c[exp_n] = 0; exp_a[exp_n] = 0; exp_n++;
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0] bb;
    bit got;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(nand_ce_n == 4'hF, "R1", "ce_n", nand_ce_n, 4'hF);
    chk(nand_we_n && nand_re_n && !nand_cle && !nand_ale && !irq, "R1", "pins",
        {nand_we_n, nand_re_n, nand_cle, nand_ale, irq}, 5'b11000);
    rreg(4'd0, d);
    chk(d == 0, "R1", "ctrl", d, 0);

    // R12 saturation
    wreg(4'd4, 32'd4095); rreg(4'd4, d);
    chk(d == DEPTH, "R12", "size sat", d, DEPTH);
    wreg(4'd4, 32'd7); rreg(4'd4, d);
    chk(d == 7, "R12", "size small", d, 7);

    // random operations: R2 R3 R4 R5 R6 R7 R10
    for (int it = 0; it < 30; it++) begin
      logic [14:0] code;
      logic [7:0] c1, c2, c3;
      logic [15:0] col;
      logic [23:0] row;
      logic [3:0] cs, rbs;
      int size, pw, hold, ofs, bad, firstbad;
      code = 15'($urandom);
      if (it == 0) code = 15'h7FFC;
      if (it == 1) code = 15'h4000;
      c1 = 8'($urandom); c2 = 8'($urandom); c3 = 8'($urandom);
      col = 16'($urandom); row = 24'($urandom);
      cs = 4'(1 << ($urandom % 4)); rbs = 4'($urandom);
      size = (it == 2) ? 0 : int'($urandom % 9);
      pw = int'($urandom % 4); hold = int'($urandom % 4);
      for (int i = 0; i < size; i++) begin mdl[i] = 8'($urandom); wbuf(i, mdl[i]); end
      wreg(4'd1, {c2, c3, 16'h0});
      wreg(4'd2, {16'h0, col});
      wreg(4'd3, {rbs, cs, row});
      wreg(4'd4, size);
      wreg(4'd5, {24'h0, 4'(hold), 4'(pw)});
      nand_rb = 4'hF;
      build_exp(code, c1, c2, c3, col, row, size);
      arm();
      go(c1, code);
      wait_irq(got);
      repeat (2) @(negedge clk);
      mon_on = 0;
      chk(got, "R10", "irq at finish", got, 1);
      rreg(4'd6, d);
      chk(d[30] && d[29] && !d[28], "R10", "flags", d[30:28], 3'b110);
      chk(we_cnt == exp_n, "R2", "write strobe count", we_cnt, exp_n);
      bad = 0; firstbad = -1;
      for (int i = 0; i < exp_n && i < we_cnt; i++)
        if (log_b[i] !== exp_b[i] || log_c[i] !== exp_c[i] || log_a[i] !== exp_a[i]) begin
          bad++; if (firstbad < 0) firstbad = i;
        end
      if (firstbad >= 0)
        chk(0, "R3", "cycle byte/cle/ale", {log_c[firstbad], log_a[firstbad], log_b[firstbad]},
            {exp_c[firstbad], exp_a[firstbad], exp_b[firstbad]});
      else chk(1, "R3", "cycle sequence", 0, 0);
      if (we_cnt > 0) chk(log_ce[0] == ~cs, "R7", "ce_n during op", log_ce[0], ~cs);
      chk(re_cnt == ((code[5] ? size : 0) + (code[3] ? 1 : 0) + (code[2] ? 4 : 0)),
          "R4", "read strobe count", re_cnt,
          (code[5] ? size : 0) + (code[3] ? 1 : 0) + (code[2] ? 4 : 0));
      if (we_cnt > 0 && last_we_low > 0)
        chk(last_we_low == pw + 1, "R6", "we low width", last_we_low, pw + 1);
      ofs = 0;
      if (code[5]) begin
        for (int i = 0; i < size; i++) begin
          rbuf(i, bb);
          chk(bb == sbyte(i), "R4", "read data in buffer", bb, sbyte(i));
        end
        ofs = size;
      end
      if (code[3]) begin
        rreg(4'd7, d);
        chk(d[7:0] == sbyte(ofs), "R5", "status byte", d[7:0], sbyte(ofs));
        ofs++;
      end
      if (code[2]) begin
        rreg(4'd8, d);
        chk(d == {sbyte(ofs+3), sbyte(ofs+2), sbyte(ofs+1), sbyte(ofs)}, "R5", "id bytes",
            d, {sbyte(ofs+3), sbyte(ofs+2), sbyte(ofs+1), sbyte(ofs)});
      end
      chk(nand_ce_n == 4'hF, "R7", "ce_n idle", nand_ce_n, 4'hF);
    end

    // R8 stall on busy line, R11 writes ignored while busy
    wreg(4'd1, 32'h00B3_0000);
    wreg(4'd2, 32'h0000_1234);
    wreg(4'd3, 32'h2100_0000);
    wreg(4'd5, 32'h0000_0000);
    wbuf(0, 8'h11);
    nand_rb = 4'b1101;
    arm();
    go(8'hA1, 15'h4050);
    repeat (40) @(negedge clk);
    chk(we_cnt == 1, "R8", "no cycle during wait", we_cnt, 1);
    wreg(4'd2, 32'h0000_BEEF);
    rreg(4'd2, d);
    chk(d[15:0] == 16'h1234, "R11", "col write while busy", d[15:0], 16'h1234);
    rreg(4'd0, d);
    chk(d[0] == 1'b1, "R11", "busy readback", d[0], 1);
    wbuf(0, 8'h77);
    nand_rb = 4'hF;
    wait_irq(got);
    mon_on = 0;
    chk(we_cnt == 2 && log_b[1] == 8'hB3, "R8", "trailing command after wait",
        log_b[1], 8'hB3);
    rbuf(0, bb);
    chk(bb == 8'h11, "R11", "buffer write while busy", bb, 8'h11);

    // R9 timeout
    nand_rb = 4'b1101;
    arm();
    go(8'hA1, 15'h4050);
    wait_irq(got);
    mon_on = 0;
    rreg(4'd6, d);
    chk(got && d[28] && !d[30] && d[29], "R9", "timeout flags", d[30:28], 3'b011);
    chk(we_cnt == 1, "R9", "remaining cycles dropped", we_cnt, 1);

    // R8 empty selection means ready
    wreg(4'd3, 32'h0100_0000);
    arm();
    go(8'hA1, 15'h0050);
    wait_irq(got);
    mon_on = 0;
    rreg(4'd6, d);
    chk(got && d[30] && !d[28], "R8", "empty selection ready", d[30:28], 3'b110);
    nand_rb = 4'hF;

    // R10 clear bits and disabled interrupt
    wreg(4'd6, 32'h0007_0000);
    rreg(4'd6, d);
    chk(d[30:28] == 3'b000 && !irq, "R10", "w1c flags", d[30:28], 0);
    wreg(4'd1, 32'h00C4_0000);
    go(8'h00, 15'h0010);
    repeat (30) @(negedge clk);
    rreg(4'd6, d);
    chk(d[29] && !irq, "R10", "idle flag without enable", {d[29], irq}, 2'b10);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule